// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox between a host processor and an embedded management controller. The host loads up to four 32-bit payload words into an outbound buffer, then writes a command word. That write marks the mailbox busy, captures the command for the controller and sends a one-cycle request pulse to the controller.

The controller reads the captured command word and the payload through its own read port. It places any reply in an inbound buffer and then ends the exchange with a one-cycle done strobe. The strobe carries an error flag and an 8-bit error code. The host can learn of completion in two ways. It can poll the status word until busy falls, or it can set the completion-interrupt flag in the command word and receive an edge-type pulse that needs no clearing.

Both ports are plain single-cycle register ports. Host reads are combinational on the address. The host can read the reply buffer as whole words or as single bytes.

Top module: `host_ctrl_mailbox`

## Requirements
- R1: After reset the status word reads 0, all words of both buffers read 0 on their ports, and neither interrupt output is asserted.
- R2: A host write to offset 0x00 while idle sets busy (status bit 0) from the next cycle on. It latches the sub-id (command bits 15:12) into status bits 7:4 and the initiator id input into status bits 15:8. It clears the error bit (status bit 1), and it pulses `ctl_req_irq` for exactly one cycle.
- R3: The accepted command word reads unchanged at controller index 0. Its fields are: code in bits 7:0, completion-interrupt flag in bit 8, sub-id in bits 15:12 and byte count in bits 23:16.
- R4: A host word write to offset 0x80+4*i while idle stores the word, and the controller reads it back at index 1+i (i = 0..3).
- R5: While busy, host writes to the command offset and to the outbound buffer have no effect, and no further controller pulse is raised.
- R6: A done strobe while busy clears busy in the next cycle. It sets status bit 1 to the error flag and status bits 23:16 to the error code. A done strobe while idle changes nothing.
- R7: `host_done_irq` pulses for exactly one cycle, in the cycle after an accepted done strobe, if and only if bit 8 of the pending command was 1.
- R8: Controller writes at inbound index i (0..3) are returned by host word reads at 0x90+4*i. Host writes to 0x90..0x9C have no effect.
- R9: With `host_byte_rd` high, a read in 0x90..0x9F returns byte (address bits 1:0) of the addressed word in bits 7:0, with byte 0 taken from word bits 7:0. Bits 31:8 read 0.
- R10: Status reserved bits 3:2 and 31:24 read 0, and a host read of the write-only offset 0x00 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_byte_rd | input | 1 | Host read is a single-byte read |
| host_init_id | input | 8 | Initiator id captured with each accepted command |
| host_rdata | output | 32 | Host read data (combinational) |
| host_done_irq | output | 1 | One-cycle completion pulse to host |
| ctl_req_irq | output | 1 | One-cycle new-command pulse to controller |
| ctl_rd_idx | input | 3 | Controller read index: 0 = command, 1..4 = payload words |
| ctl_rdata | output | 32 | Controller read data (combinational) |
| ctl_wr | input | 1 | Controller write strobe for the reply buffer |
| ctl_wr_idx | input | 2 | Reply buffer word index |
| ctl_wdata | input | 32 | Reply word |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Error flag carried by the done strobe |
| ctl_err_code | input | 8 | Error code carried by the done strobe |

## Verification
The assertions take the controller to follow the handshake: it raises `ctl_done` only as a single-cycle strobe, and the control logic is expected to ignore a strobe that arrives while idle. No assertion assumes that the host stays quiet while busy. The stimulus keeps every strobe one cycle wide and drives inputs only between clock edges. It deliberately sends extra command writes, payload writes and an idle-time done strobe, so that the ignore paths are exercised inside these limits.

// File: rtl/mbx_pkg.sv
// Package: shared constants and the command word layout for the mailbox.
// Assumes a byte-addressed host map with 32-bit words.
package mbx_pkg;
    localparam int WORD_W    = 32;
    localparam int BUF_WORDS = 4;
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [3:0] PAGE_OUT = 4'h8;   // 0x80..0x8F
    localparam logic [3:0] PAGE_IN  = 4'h9;   // 0x90..0x9F

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] nbytes;
        logic [3:0] sub_id;
        logic [2:0] rsv_lo;
        logic       want_irq;
        logic [7:0] code;
    } mbx_cmd_t;
endpackage

// File: rtl/mbx_wordbuf.sv
// Module: small word buffer with one write port and one combinational read port.
// Assumes indices are in range; contents clear on reset.
module mbx_wordbuf #(
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Store one word when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 mem[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))         mem[g] <= wr_data;
        end
    end

    // Return the selected word.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/mbx_seq.sv
// Module: busy/status sequencing and the two interrupt pulses.
// Assumes ctl_done is a single-cycle strobe; a strobe while idle is ignored.
module mbx_seq
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    input  logic [7:0]  init_id,
    input  logic        done,
    input  logic        err,
    input  logic [7:0]  err_code,
    output logic        busy,
    output mbx_cmd_t    cmd_q,
    output logic [31:0] status,
    output logic        req_irq,
    output logic        done_irq
);
    logic       err_q;
    logic [7:0] code_q;
    logic [7:0] init_q;
    logic       accept, finish;

    // Qualify both events against the busy state.
    always_comb begin
        accept = cmd_wr && !busy;
        finish = done && busy;
    end

    // Track busy, command capture and completion fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cmd_q  <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            init_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cmd_q  <= mbx_cmd_t'(cmd_word);
            err_q  <= 1'b0;
            init_q <= init_id;
        end else if (finish) begin
            busy   <= 1'b0;
            err_q  <= err;
            code_q <= err_code;
        end
    end

    // Generate the one-cycle interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_irq  <= 1'b0;
            done_irq <= 1'b0;
        end else begin
            req_irq  <= accept;
            done_irq <= finish && cmd_q.want_irq;
        end
    end

    // Assemble the status word.
    always_comb status = {8'h00, code_q, init_q, cmd_q.sub_id, 2'b00, err_q, busy};

    a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (busy && req_irq));
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_irq |=> !req_irq);
    a_r5_no_reirq: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !req_irq);
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |=> !busy);
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy) |=> !done_irq);
    a_r7_irq_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy && cmd_q.want_irq) |=> done_irq);
endmodule

// File: rtl/host_ctrl_mailbox.sv
// Module: top of the mailbox; host address decode, buffers and sequencing.
// Assumes single-cycle host and controller accesses; host reads are combinational.
module host_ctrl_mailbox
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic        host_byte_rd,
    input  logic [7:0]  host_init_id,
    output logic [31:0] host_rdata,
    output logic        host_done_irq,
    output logic        ctl_req_irq,
    input  logic [2:0]  ctl_rd_idx,
    output logic [31:0] ctl_rdata,
    input  logic        ctl_wr,
    input  logic [1:0]  ctl_wr_idx,
    input  logic [31:0] ctl_wdata,
    input  logic        ctl_done,
    input  logic        ctl_err,
    input  logic [7:0]  ctl_err_code
);
    localparam int IW = $clog2(BUF_WORDS);

    logic        busy;
    mbx_cmd_t    cmd_q;
    logic [31:0] status;
    logic        cmd_wr, out_wr;
    logic [31:0] out_word, in_word;
    logic [IW-1:0] out_rd_idx;

    // Decode host writes; payload writes are word-aligned and blocked while busy.
    always_comb begin
        cmd_wr = host_wr && host_addr == OFS_CMD;
        out_wr = host_wr && !busy && host_addr[7:4] == PAGE_OUT && host_addr[1:0] == 2'b00;
    end

    // Map the controller index onto the outbound buffer.
    always_comb out_rd_idx = IW'(ctl_rd_idx - 3'd1);

    mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(WORD_W)) u_outbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(out_wr), .wr_idx(host_addr[IW+1:2]), .wr_data(host_wdata),
        .rd_idx(out_rd_idx), .rd_data(out_word)
    );

    mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(WORD_W)) u_inbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ctl_wr), .wr_idx(ctl_wr_idx), .wr_data(ctl_wdata),
        .rd_idx(host_addr[IW+1:2]), .rd_data(in_word)
    );

    mbx_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_word(host_wdata), .init_id(host_init_id),
        .done(ctl_done), .err(ctl_err), .err_code(ctl_err_code),
        .busy(busy), .cmd_q(cmd_q), .status(status),
        .req_irq(ctl_req_irq), .done_irq(host_done_irq)
    );

    // Host read mux: status, reply words or little-endian reply bytes.
    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_STAT)
            host_rdata = status;
        else if (host_addr[7:4] == PAGE_IN)
            host_rdata = host_byte_rd ? {24'h0, in_word[8*host_addr[1:0] +: 8]} : in_word;
    end

    // Controller read mux: command word or payload words.
    always_comb begin
        if (ctl_rd_idx == 3'd0)                   ctl_rdata = cmd_q;
        else if (ctl_rd_idx <= 3'(BUF_WORDS))     ctl_rdata = out_word;
        else                                      ctl_rdata = '0;
    end

    a_r10_status_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b00 && status[31:24] == 8'h00));
endmodule

// File: tb/host_ctrl_mailbox_tb.sv
module host_ctrl_mailbox_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic host_wr = 0, host_byte_rd = 0, ctl_wr = 0, ctl_done = 0, ctl_err = 0;
    logic [7:0]  host_addr = 0, host_init_id = 0, ctl_err_code = 0;
    logic [31:0] host_wdata = 0, ctl_wdata = 0;
    logic [2:0]  ctl_rd_idx = 0;
    logic [1:0]  ctl_wr_idx = 0;
    logic [31:0] host_rdata, ctl_rdata;
    logic        host_done_irq, ctl_req_irq;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // reference model state
    logic        m_busy, m_err, m_cirq, m_hirq;
    logic [31:0] m_cmd;
    logic [7:0]  m_code, m_init;
    logic [31:0] m_out [4];
    logic [31:0] m_in  [4];

    host_ctrl_mailbox u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {8'h00, m_code, m_init, m_cmd[15:12], 2'b00, m_err, m_busy};
    endfunction

    // behavioural reference, updated on each edge from the inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_cirq = 0; m_hirq = 0;
            m_cmd = 0; m_code = 0; m_init = 0;
            for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_in[i] = 0; end
        end else begin
            m_cirq = 0; m_hirq = 0;
            if (ctl_wr) m_in[ctl_wr_idx] = ctl_wdata;
            if (!m_busy && host_wr && host_addr >= 8'h80 && host_addr <= 8'h8C && host_addr[1:0] == 0)
                m_out[host_addr[3:2]] = host_wdata;
            if (ctl_done && m_busy) begin
                m_busy = 0; m_err = ctl_err; m_code = ctl_err_code; m_hirq = m_cmd[8];
            end else if (!m_busy && host_wr && host_addr == 8'h00) begin
                m_busy = 1; m_err = 0; m_cmd = host_wdata; m_init = host_init_id; m_cirq = 1;
            end
        end
    end

    // compare the interrupt outputs on every clock (R1, R2, R5, R7)
    always @(negedge clk) if (rst_n) begin
        cyc++;
        check("R2/R5 ctl_req_irq", {31'h0, ctl_req_irq}, {31'h0, m_cirq});
        check("R7 host_done_irq", {31'h0, host_done_irq}, {31'h0, m_hirq});
    end

    task automatic hwrite(logic [7:0] a, logic [31:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hread(string req, logic [7:0] a, logic byt, logic [31:0] exp);
        @(negedge clk); host_addr = a; host_byte_rd = byt; #1;
        check(req, host_rdata, exp);
        host_byte_rd = 0;
    endtask

    task automatic cread(string req, logic [2:0] idx, logic [31:0] exp);
        @(negedge clk); ctl_rd_idx = idx; #1;
        check(req, ctl_rdata, exp);
    endtask

    task automatic cwrite(logic [1:0] idx, logic [31:0] d);
        @(negedge clk); ctl_wr = 1; ctl_wr_idx = idx; ctl_wdata = d;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic cdone(logic e, logic [7:0] code);
        @(negedge clk); ctl_done = 1; ctl_err = e; ctl_err_code = code;
        @(negedge clk); ctl_done = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        hread("R1 status", 8'h04, 0, 32'h0);
        for (int i = 0; i < 4; i++) hread("R1 inbuf", 8'h90 + 8'(4*i), 0, 32'h0);
        for (int i = 0; i < 5; i++) cread("R1 ctl port", 3'(i), 32'h0);
        check("R1 irqs", {30'h0, ctl_req_irq, host_done_irq}, 32'h0);
        // R4 payload words
        for (int i = 0; i < 4; i++) hwrite(8'h80 + 8'(4*i), 32'hA0B0C000 + 32'(i*17));
        for (int i = 0; i < 4; i++) cread("R4 payload", 3'(i+1), m_out[i]);
        check("R4 model", m_out[2], 32'hA0B0C022);
        // R2/R3 command with completion interrupt
        host_init_id = 8'h3C;
        hwrite(8'h00, 32'h0010_31A5);
        cread("R3 cmd word", 0, 32'h0010_31A5);
        hread("R2 status busy", 8'h04, 0, 32'h0000_3C31);
        // R5 ignored while busy
        hwrite(8'h00, 32'h00FF_F0EE);
        hwrite(8'h80, 32'hDEADBEEF);
        cread("R5 cmd unchanged", 0, 32'h0010_31A5);
        cread("R5 payload unchanged", 1, 32'hA0B0C000);
        // R8 reply buffer
        cwrite(0, 32'h44332211);
        cwrite(3, 32'h8877_6655);
        hwrite(8'h90, 32'h12345678);
        hread("R8 in0", 8'h90, 0, 32'h44332211);
        hread("R8 in3", 8'h9C, 0, 32'h88776655);
        // R6/R7 done with error
        cdone(1, 8'h5C);
        hread("R6 status err", 8'h04, 0, 32'h005C_3C32);
        // R9 byte reads
        hread("R9 byte0", 8'h90, 1, 32'h11);
        hread("R9 byte2", 8'h92, 1, 32'h33);
        hread("R9 byte3", 8'h9F, 1, 32'h88);
        // R2 new command clears error, no interrupt requested
        host_init_id = 8'h07;
        hwrite(8'h00, 32'h0000_9001);
        hread("R2 err cleared", 8'h04, 0, m_status());
        check("R2 err bit", {31'h0, m_status()[1]}, 32'h0);
        cdone(0, 8'h00);
        hread("R6 ok status", 8'h04, 0, 32'h0000_0790);
        // R6 done while idle ignored
        cdone(1, 8'hAA);
        hread("R6 idle done", 8'h04, 0, 32'h0000_0790);
        // R10 write-only offset reads zero
        hread("R10 cmd read", 8'h00, 0, 32'h0);
        hread("R10 status model", 8'h04, 0, m_status());
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule